// File: doc/BRIEF.md
# Multi-Mode Shifter Operand Path with Flag Merge

This block sits in front of the A operand of a 16-bit ALU. A word taken from the A bus is held in an operand latch. A combinational log-stage barrel shifter reads that latched word. It applies one of eight shift modes over a distance of 0 to 15, using a carry-in bit, and produces a shifted word and a carry-out. A select input chooses whether the ALU sees the latched word or the shifted word.

The block also merges the condition flags. A small ALU (pass-A or add-with-carry) forms the result. N and Z always follow that result. C comes from the shifter only when the shifter path is selected and the ALU passes A through. Otherwise C comes from the ALU. All three flags are registered at every clock edge.

Top module: `shx_operand_unit`

## Requirements
- R1: After reset the operand latch and all three flags are 0. The latch captures `a_bus` on a rising edge with `a_load` high and keeps its value while `a_load` is low.
- R2: With `sel_latched`=1 the ALU A input is the latched word. With `sel_latched`=0 it is the shifter output.
- R3: Modes 0 (logical left) and 2 (arithmetic left) shift the word left by `shift_dist` and fill with zeros. The carry-out is the last bit shifted out, which is input bit 16-d.
- R4: Mode 1 (logical right) fills with zeros and mode 3 (arithmetic right) fills with copies of bit 15. For both, the carry-out is input bit d-1.
- R5: Modes 4 (rotate left) and 5 (rotate right) rotate the 16-bit word. The carry-out is the bit that wrapped last: result bit 0 for left and result bit 15 for right.
- R6: Modes 6 and 7 rotate left and right through a 17-bit ring. Bit 16 of the ring is `carry_in` and bits 15..0 are the word. After the rotation, ring bit 16 is the carry-out.
- R7: With `shift_dist`=0 every mode returns the word unchanged and gives `carry_in` as the carry-out.
- R8: `alu_op`=0 passes the A input to the result with an ALU carry of 0. `alu_op`=1 gives A + `b_operand` + `carry_in`, with the ALU carry equal to the 17th sum bit.
- R9: At each rising edge, `flag_c` takes the shifter carry-out when `alu_op`=0 and `sel_latched`=0. In every other case it takes the ALU carry.
- R10: At each rising edge, `flag_n` takes result bit 15 and `flag_z` takes (result == 0). This also applies when a shifted word passes through.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_bus | input | 16 | Word offered to the operand latch |
| a_load | input | 1 | Latch enable for `a_bus` |
| b_operand | input | 16 | ALU B input |
| sel_latched | input | 1 | 1 selects the latched word, 0 the shifter output |
| shift_mode | input | 3 | Shift mode code 0..7 |
| shift_dist | input | 4 | Shift distance 0..15 |
| carry_in | input | 1 | Carry into both the shifter and the ALU |
| alu_op | input | 1 | 0 pass A, 1 add with carry |
| alu_result | output | 16 | Combinational ALU result |
| flag_c | output | 1 | Registered carry flag |
| flag_n | output | 1 | Registered negative flag |
| flag_z | output | 1 | Registered zero flag |

## Verification
The bench aims at distance 0 in all eight modes. A shifter that loses the carry-in there would report a stale or zero C. It also drives distance 15 and single-bit rotations through the carry ring with a set MSB, where an off-by-one ring width would drop or duplicate the carry bit.

Arithmetic right shifts of negative words catch a design that fills with zeros instead of copies of the sign bit. Add operations with the shifter selected check that the ALU carry overrides the shifter carry, which a flag merge keyed on the select alone would get wrong.

// File: rtl/shx_pkg.sv
package shx_pkg;

   typedef enum logic [2:0] {
      SH_SLL   = 3'd0,
      SH_SRL   = 3'd1,
      SH_SLA   = 3'd2,
      SH_SRA   = 3'd3,
      SH_ROTL  = 3'd4,
      SH_ROTR  = 3'd5,
      SH_ROTLC = 3'd6,
      SH_ROTRC = 3'd7
   } shift_mode_e;

   typedef enum logic {
      ALU_PASS_A = 1'b0,
      ALU_ADD    = 1'b1
   } alu_op_e;

endpackage

// File: rtl/shx_barrel.sv
module shx_barrel
   import shx_pkg::*;
#(
   parameter int WIDTH  = 16,
   parameter int DIST_W = 4
) (
   input  logic [WIDTH-1:0]  data_i,
   input  logic [DIST_W-1:0] dist_i,
   input  shift_mode_e       mode_i,
   input  logic              carry_i,
   output logic [WIDTH-1:0]  data_o,
   output logic              carry_o
);

   localparam int STAGES = DIST_W;
   localparam int RING_W = WIDTH + 1;

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("shx_barrel: WIDTH must be at least 2");
      end
      if ((1 << DIST_W) > WIDTH) begin : g_bad_dist
         $error("shx_barrel: largest distance must not exceed WIDTH-1");
      end
   endgenerate

   logic [WIDTH-1:0] st_d [0:STAGES];
   logic             st_c [0:STAGES];

   assign st_d[0] = data_i;
   assign st_c[0] = carry_i;

   generate
      for (genvar k = 0; k < STAGES; k++) begin : g_stage
         localparam int AMT = 1 << k;
         logic [WIDTH-1:0]    din;
         logic                cin;
         logic [2*WIDTH-1:0]  dbl;
         logic [2*RING_W-1:0] ring2;
         logic [RING_W-1:0]   ring;
         logic [WIDTH-1:0]    dnext;
         logic                cnext;

         assign din = st_d[k];
         assign cin = st_c[k];

         always_comb begin
            dbl   = '0;
            ring2 = '0;
            ring  = '0;
            dnext = din;
            cnext = cin;
            unique case (mode_i)
               SH_SLL, SH_SLA: begin
                  dnext = din << AMT;
                  cnext = din[WIDTH-AMT];
               end
               SH_SRL: begin
                  dnext = din >> AMT;
                  cnext = din[AMT-1];
               end
               SH_SRA: begin
                  dnext = $signed(din) >>> AMT;
                  cnext = din[AMT-1];
               end
               SH_ROTL: begin
                  dbl   = {din, din} << AMT;
                  dnext = dbl[2*WIDTH-1:WIDTH];
                  cnext = dnext[0];
               end
               SH_ROTR: begin
                  dbl   = {din, din} >> AMT;
                  dnext = dbl[WIDTH-1:0];
                  cnext = dnext[WIDTH-1];
               end
               SH_ROTLC: begin
                  ring2 = {cin, din, cin, din} << AMT;
                  ring  = ring2[2*RING_W-1:RING_W];
                  dnext = ring[WIDTH-1:0];
                  cnext = ring[WIDTH];
               end
               SH_ROTRC: begin
                  ring2 = {cin, din, cin, din} >> AMT;
                  ring  = ring2[RING_W-1:0];
                  dnext = ring[WIDTH-1:0];
                  cnext = ring[WIDTH];
               end
               default: begin
                  dnext = din;
                  cnext = cin;
               end
            endcase
         end

         assign st_d[k+1] = dist_i[k] ? dnext : din;
         assign st_c[k+1] = dist_i[k] ? cnext : cin;
      end
   endgenerate

   assign data_o  = st_d[STAGES];
   assign carry_o = st_c[STAGES];

endmodule

// File: rtl/shx_alu.sv
module shx_alu
   import shx_pkg::*;
#(
   parameter int WIDTH = 16
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  logic             carry_i,
   input  alu_op_e          op_i,
   output logic [WIDTH-1:0] res_o,
   output logic             carry_o
);

   logic [WIDTH:0] sum;

   assign sum = {1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, carry_i};

   always_comb begin
      unique case (op_i)
         ALU_ADD: begin
            res_o   = sum[WIDTH-1:0];
            carry_o = sum[WIDTH];
         end
         default: begin
            res_o   = a_i;
            carry_o = 1'b0;
         end
      endcase
   end

endmodule

// File: rtl/shx_flags.sv
module shx_flags
   import shx_pkg::*;
#(
   parameter int WIDTH = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] res_i,
   input  logic             alu_carry_i,
   input  logic             shift_carry_i,
   input  alu_op_e          op_i,
   input  logic             sel_latched_i,
   output logic             flag_c_o,
   output logic             flag_n_o,
   output logic             flag_z_o
);

   logic take_shift_c;
   logic c_next;
   logic z_next;

   assign take_shift_c = (op_i == ALU_PASS_A) && !sel_latched_i;
   assign c_next       = take_shift_c ? shift_carry_i : alu_carry_i;
   assign z_next       = ~|res_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_c_o <= 1'b0;
         flag_n_o <= 1'b0;
         flag_z_o <= 1'b0;
      end else begin
         flag_c_o <= c_next;
         flag_n_o <= res_i[WIDTH-1];
         flag_z_o <= z_next;
      end
   end

   a_r9_c_from_shifter: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == ALU_PASS_A && !sel_latched_i) |=> (flag_c_o == $past(shift_carry_i)));

   a_r9_c_from_alu: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == ALU_ADD || sel_latched_i) |=> (flag_c_o == $past(alu_carry_i)));

   a_r10_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (flag_z_o == ($past(res_i) == '0)));

   a_r10_neg_flag: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (flag_n_o == $past(res_i[WIDTH-1])));

endmodule

// File: rtl/shx_operand_unit.sv
module shx_operand_unit
   import shx_pkg::*;
#(
   parameter int WIDTH  = 16,
   parameter int DIST_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WIDTH-1:0]  a_bus,
   input  logic              a_load,
   input  logic [WIDTH-1:0]  b_operand,
   input  logic              sel_latched,
   input  logic [2:0]        shift_mode,
   input  logic [DIST_W-1:0] shift_dist,
   input  logic              carry_in,
   input  logic              alu_op,
   output logic [WIDTH-1:0]  alu_result,
   output logic              flag_c,
   output logic              flag_n,
   output logic              flag_z
);

   logic [WIDTH-1:0] a_q;
   logic [WIDTH-1:0] sh_data;
   logic             sh_carry;
   logic [WIDTH-1:0] alu_a;
   logic             alu_carry;
   shift_mode_e      mode;
   alu_op_e          op;

   assign mode = shift_mode_e'(shift_mode);
   assign op   = alu_op_e'(alu_op);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      a_q <= '0;
      else if (a_load) a_q <= a_bus;
   end

   shx_barrel #(.WIDTH(WIDTH), .DIST_W(DIST_W)) u_barrel (
      .data_i  (a_q),
      .dist_i  (shift_dist),
      .mode_i  (mode),
      .carry_i (carry_in),
      .data_o  (sh_data),
      .carry_o (sh_carry)
   );

   assign alu_a = sel_latched ? a_q : sh_data;

   shx_alu #(.WIDTH(WIDTH)) u_alu (
      .a_i     (alu_a),
      .b_i     (b_operand),
      .carry_i (carry_in),
      .op_i    (op),
      .res_o   (alu_result),
      .carry_o (alu_carry)
   );

   shx_flags #(.WIDTH(WIDTH)) u_flags (
      .clk           (clk),
      .rst_n         (rst_n),
      .res_i         (alu_result),
      .alu_carry_i   (alu_carry),
      .shift_carry_i (sh_carry),
      .op_i          (op),
      .sel_latched_i (sel_latched),
      .flag_c_o      (flag_c),
      .flag_n_o      (flag_n),
      .flag_z_o      (flag_z)
   );

   a_r1_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !a_load |=> $stable(a_q));

   a_r2_latched_path: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_latched && op == ALU_PASS_A) |-> (alu_result == a_q));

   a_r7_zero_distance: assert property (@(posedge clk) disable iff (!rst_n)
      (shift_dist == '0) |-> (sh_data == a_q && sh_carry == carry_in));

   a_r5_rotate_keeps_ones: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == SH_ROTL || mode == SH_ROTR) |-> ($countones(sh_data) == $countones(a_q)));

   a_r6_ring_keeps_ones: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == SH_ROTLC || mode == SH_ROTRC) |->
         ($countones({sh_carry, sh_data}) == $countones({carry_in, a_q})));

endmodule

// File: tb/shx_operand_unit_tb.sv
`timescale 1ns/1ps
module shx_operand_unit_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] a_bus = '0;
   logic        a_load = 1'b0;
   logic [15:0] b_operand = '0;
   logic        sel_latched = 1'b1;
   logic [2:0]  shift_mode = '0;
   logic [3:0]  shift_dist = '0;
   logic        carry_in = 1'b0;
   logic        alu_op = 1'b0;
   logic [15:0] alu_result;
   logic        flag_c, flag_n, flag_z;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   shx_operand_unit u_dut (
      .clk(clk), .rst_n(rst_n), .a_bus(a_bus), .a_load(a_load),
      .b_operand(b_operand), .sel_latched(sel_latched),
      .shift_mode(shift_mode), .shift_dist(shift_dist),
      .carry_in(carry_in), .alu_op(alu_op), .alu_result(alu_result),
      .flag_c(flag_c), .flag_n(flag_n), .flag_z(flag_z)
   );

   // reference: single-bit steps repeated
   function automatic logic [16:0] ref_shift(logic [15:0] d, logic [2:0] m,
                                             logic [3:0] n, logic c);
      for (int i = 0; i < int'(n); i++) begin
         logic nc;
         case (m)
            3'd0, 3'd2: begin nc = d[15]; d = {d[14:0], 1'b0}; end
            3'd1:       begin nc = d[0];  d = {1'b0, d[15:1]}; end
            3'd3:       begin nc = d[0];  d = {d[15], d[15:1]}; end
            3'd4:       begin d = {d[14:0], d[15]}; nc = d[0]; end
            3'd5:       begin d = {d[0], d[15:1]}; nc = d[15]; end
            3'd6:       begin nc = d[15]; d = {d[14:0], c}; end
            default:    begin nc = d[0];  d = {c, d[15:1]}; end
         endcase
         c = nc;
      end
      return {c, d};
   endfunction

   function automatic string mode_tag(logic [2:0] m, logic [3:0] n);
      if (n == 0) return "R7";
      case (m)
         3'd0, 3'd2: return "R3";
         3'd1, 3'd3: return "R4";
         3'd4, 3'd5: return "R5";
         default:    return "R6";
      endcase
   endfunction

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic run_vec(logic [15:0] a, logic sel, logic [2:0] m, logic [3:0] n,
                          logic c, logic op, logic [15:0] b);
      logic [16:0] sh;
      logic [15:0] opa, res;
      logic [16:0] sum;
      logic        alc, ec;
      string       tag;
      sh  = ref_shift(a, m, n, c);
      opa = sel ? a : sh[15:0];
      sum = {1'b0, opa} + {1'b0, b} + {16'd0, c};
      res = op ? sum[15:0] : opa;
      alc = op ? sum[16] : 1'b0;
      ec  = (!op && !sel) ? sh[16] : alc;
      tag = sel ? "R2" : mode_tag(m, n);
      if (op) tag = {tag, "/R8"};
      @(negedge clk);
      a_bus = a; a_load = 1'b1; sel_latched = sel; shift_mode = m;
      shift_dist = n; carry_in = c; alu_op = op; b_operand = b;
      @(negedge clk);
      a_load = 1'b0; a_bus = ~a;
      check(tag, {16'd0, alu_result}, {16'd0, res});
      @(negedge clk);
      check((!op && !sel) ? "R9 shifter carry" : "R9 alu carry",
            {31'd0, flag_c}, {31'd0, ec});
      check("R10 n/z", {30'd0, flag_n, flag_z}, {30'd0, res[15], res == 16'd0});
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check("R1 reset result", {16'd0, alu_result}, 32'd0);
      check("R1 reset flags", {29'd0, flag_c, flag_n, flag_z}, 32'd0);
      rst_n = 1'b1;

      // directed corners
      for (int m = 0; m < 8; m++) run_vec(16'hA5C3, 1'b0, 3'(m), 4'd0, 1'b1, 1'b0, 16'd0);
      for (int m = 0; m < 8; m++) run_vec(16'h8001, 1'b0, 3'(m), 4'd15, 1'b0, 1'b0, 16'd0);
      run_vec(16'h8000, 1'b0, 3'd6, 4'd1, 1'b0, 1'b0, 16'd0); // ring: 0x0000, C=1
      run_vec(16'h0001, 1'b0, 3'd7, 4'd1, 1'b1, 1'b0, 16'd0); // ring: 0x8000, C=1
      run_vec(16'h8000, 1'b0, 3'd3, 4'd4, 1'b0, 1'b0, 16'd0); // sign fill 0xF800
      run_vec(16'h8000, 1'b0, 3'd1, 4'd4, 1'b1, 1'b0, 16'd0);
      run_vec(16'h0000, 1'b0, 3'd0, 4'd3, 1'b1, 1'b0, 16'd0); // Z set
      run_vec(16'hFFFF, 1'b0, 3'd0, 4'd1, 1'b0, 1'b1, 16'h0001); // shifter C overridden
      run_vec(16'h1234, 1'b1, 3'd4, 4'd5, 1'b1, 1'b0, 16'd0);    // latched path
      run_vec(16'hFFFF, 1'b1, 3'd0, 4'd1, 1'b1, 1'b1, 16'h0000); // add wraps to zero

      // R1: latch holds while a_load low
      @(negedge clk);
      a_bus = 16'h5A5A; a_load = 1'b1; sel_latched = 1'b1; alu_op = 1'b0;
      @(negedge clk);
      a_load = 1'b0; a_bus = 16'h1111;
      @(negedge clk);
      @(negedge clk);
      check("R1 latch hold", {16'd0, alu_result}, 32'h5A5A);

      void'($urandom(32'd20240309));
      for (int i = 0; i < 400; i++) begin
         run_vec(16'($urandom), 1'($urandom), 3'($urandom), 4'($urandom),
                 1'($urandom), 1'($urandom), 16'($urandom));
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule